// File: doc/BRIEF.md
# SPI ADC Command Sequencer

This block sits on the host side of a multi-channel successive-approximation ADC that is programmed with one-byte commands over SPI. It builds each command byte from a register-select prefix and packed fields, sends it in its own chip-select frame, and reads conversion results back as big-endian 16-bit words. A request port accepts three operations: a single read of one channel, entry into scan mode and exit from scan mode. Results come out one word at a time, with the channel index and the value already right-aligned.

The channel space holds one temperature sensor at index 0 and `NUM_VIN` voltage inputs at indices 1 to `NUM_VIN`. A single read programs the ADC so that a command write starts the conversion. The block then waits a fixed settle time of 1 ms, counted in clock cycles from `CLK_HZ`, and reads the result. In scan mode the ADC is paced by an external convert-start pin. Each falling edge on the active-low end-of-conversion input makes the block read the whole channel set in one burst, with the temperature word first.

After reset the block first writes a command that turns averaging off. It accepts requests only once that command has been sent.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `busy_o` is high and the first SPI frame is a single byte 0x20 (averaging off). `busy_o` falls only when that frame has ended. During reset `spi_cs_no` is 1, and `res_valid_o`, `err_o` and `scan_active_o` are 0.
- R2: The SPI link is mode 0, MSB first. Every command byte travels in its own chip-select frame. A data read keeps chip select low for all of its bytes, and MOSI is 0x00 during reads.
- R3: A single read of voltage index k (1..NUM_VIN) sends these frames in order: setup byte 0x68 (bits[7:6]=01, clock mode bits[5:4]=2, reference bits[3:2]=2); conversion byte 0x80 | (k-1)<<3 | 0x06 (no-scan code 11 in bits[2:1], temperature flag bit0=0); a 2-byte read frame. It reports one result with index k and data = word[11:2].
- R4: A single read of index 0 (temperature) sends 0x68, then conversion byte 0x87, then a 4-byte read frame. It reports one result with index 0 and data = bits[11:0] of the first word. Bits [15:12] of every reported result are 0.
- R5: Operation 1 (scan on) sends setup byte 0x48 (clock mode 0), then conversion byte 0x83 (channel 0, scan code 01, temperature flag set), and raises `scan_active_o`.
- R6: While scan mode is active, a falling edge on `eoc_ni` starts one read frame of 2*(NUM_VIN+1) bytes. It reports NUM_VIN+1 results with indices 0..NUM_VIN in order: index 0 is formatted as temperature and the rest as voltages. Outside scan mode, `eoc_ni` causes no SPI traffic.
- R7: Operation 2 (scan off) sends the single setup frame 0x68 and clears `scan_active_o`.
- R8: A single-read request made while scan mode is active pulses `err_o` for one cycle and causes no SPI frame.
- R9: A single read of an index at or above NUM_VIN+1, or a request with reserved operation 3, pulses `err_o` and causes no SPI frame.
- R10: A single read waits at least CLK_HZ/1000 clock cycles between the end of the conversion-byte frame and the start of the read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Request strobe, taken only while idle |
| req_op_i | input | 2 | 0 single read, 1 scan on, 2 scan off, 3 reserved |
| req_chan_i | input | CH_W | Channel index for a single read (0 = temperature) |
| eoc_ni | input | 1 | End-of-conversion strobe from the ADC, active low |
| busy_o | output | 1 | A sequence is in progress |
| scan_active_o | output | 1 | Scan mode is active |
| err_o | output | 1 | One-cycle pulse when a request is rejected |
| res_valid_o | output | 1 | Result word valid |
| res_idx_o | output | CH_W | Channel index of the result |
| res_data_o | output | 16 | Right-aligned result value |
| spi_sclk_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | SPI data to the ADC |
| spi_miso_i | input | 1 | SPI data from the ADC |
| spi_cs_no | output | 1 | SPI chip select, active low |

## Verification
Some rules hold on every clock cycle, and the assertions check those: the byte engine never gets a start while it is shifting, clock edges appear only while chip select is low, a rejection leaves chip select released, a rejection never coincides with a result, and every result has an index in range and a clear top nibble. The scenarios alone can show what depends on the whole sequence. These are the exact command bytes and their order, the length of each read frame, the settle gap, the temperature and voltage alignment of the data, and the ordered burst indices. An ADC model in the bench decodes MOSI and serves MISO words for those checks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    OP_SINGLE   = 2'd0,
    OP_SCAN_ON  = 2'd1,
    OP_SCAN_OFF = 2'd2,
    OP_RSVD     = 2'd3
  } adc_op_e;

  localparam logic [1:0] CLKM_PIN   = 2'd0;  // convert on external pin
  localparam logic [1:0] CLKM_WRITE = 2'd2;  // convert on command write
  localparam logic [1:0] REF_SEL    = 2'd2;
  localparam logic [1:0] SCAN_UP    = 2'b01;
  localparam logic [1:0] SCAN_NONE  = 2'b11;
  localparam logic [7:0] AVG_OFF    = 8'h20;

  function automatic logic [7:0] setup_byte(logic [1:0] clkm);
    return {2'b01, clkm, REF_SEL, 2'b00};
  endfunction

  function automatic logic [7:0] conv_byte(logic [3:0] ch, logic [1:0] scan, logic temp);
    return {1'b1, ch, scan, temp};
  endfunction

endpackage

// File: rtl/adc_spi_byte.sv
module adc_spi_byte #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic          act_q, sclk_q, done_q;
  logic [7:0]    tx_q, rx_q;
  logic          tick;

  assign tick = (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        tx_q   <= tx_i;
        div_q  <= '0;
        bit_q  <= '0;
        sclk_q <= 1'b0;
      end else if (act_q) begin
        if (tick) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign busy_o = act_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R2
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);

endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
  parameter int NUM_CH = 9,
  parameter int CH_W   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [15:0]     in_word_i,
  input  logic [CH_W-1:0] in_idx_i,
  output logic            res_valid_o,
  output logic [CH_W-1:0] res_idx_o,
  output logic [15:0]     res_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_idx_o   <= '0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= in_valid_i;
      if (in_valid_i) begin
        res_idx_o  <= in_idx_i;
        // index 0 is the temperature sensor: 12 bits, no shift
        res_data_o <= (in_idx_i == '0) ? {4'h0, in_word_i[11:0]}
                                       : {6'h00, in_word_i[11:2]};
      end
    end
  end

  // R6
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (32'(res_idx_o) < NUM_CH));

  // R4
  top_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_data_o[15:12] == 4'h0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH     = 9,
  parameter int CH_W       = 4,
  parameter int SETTLE_CYC = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_start_i,
  input  logic [1:0]      req_op_i,
  input  logic [CH_W-1:0] req_chan_i,
  input  logic            eoc_ni,
  output logic            busy_o,
  output logic            scan_o,
  output logic            err_o,
  output logic            cs_no,
  output logic            spi_start_o,
  output logic [7:0]      spi_tx_o,
  input  logic            spi_busy_i,
  input  logic            spi_done_i,
  input  logic [7:0]      spi_rx_i,
  output logic            word_valid_o,
  output logic [15:0]     word_o,
  output logic [CH_W-1:0] word_idx_o
);
  localparam int RD_W = $clog2(2 * NUM_CH + 1);
  localparam int IX_W = $clog2(NUM_CH + 1);
  localparam int SW   = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CS, S_GO, S_WAIT, S_GAP, S_SETTLE} st_e;

  st_e             st_q;
  logic [7:0]      cmd0_q, cmd1_q;
  logic [1:0]      ncmd_q;
  logic            rd_pend_q, reading_q, par_q, scan_q, err_q, cs_q;
  logic [RD_W-1:0] rd_tot_q, rd_left_q;
  logic [IX_W-1:0] widx_q, keep_q;
  logic [CH_W-1:0] base_q;
  logic [7:0]      hi_q;
  logic [SW-1:0]   cnt_q;
  logic [2:0]      eoc_sync_q;
  logic            eoc_fall, chan_ok;

  assign eoc_fall = eoc_sync_q[2] & ~eoc_sync_q[1];
  assign chan_ok  = 32'(req_chan_i) < NUM_CH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_CS;            // boot: averaging-off frame first
      cmd0_q     <= AVG_OFF;
      cmd1_q     <= '0;
      ncmd_q     <= 2'd1;
      rd_pend_q  <= 1'b0;
      reading_q  <= 1'b0;
      par_q      <= 1'b0;
      scan_q     <= 1'b0;
      err_q      <= 1'b0;
      cs_q       <= 1'b1;
      rd_tot_q   <= '0;
      rd_left_q  <= '0;
      widx_q     <= '0;
      keep_q     <= '0;
      base_q     <= '0;
      hi_q       <= '0;
      cnt_q      <= '0;
      eoc_sync_q <= 3'b111;
    end else begin
      eoc_sync_q <= {eoc_sync_q[1:0], eoc_ni};
      err_q      <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (req_start_i) begin
            unique case (adc_op_e'(req_op_i))
              OP_SINGLE: begin
                if (scan_q || !chan_ok) err_q <= 1'b1;
                else begin
                  cmd0_q    <= setup_byte(CLKM_WRITE);
                  cmd1_q    <= (req_chan_i == '0) ? conv_byte(4'd0, SCAN_NONE, 1'b1)
                                                  : conv_byte(4'(req_chan_i - 1'b1), SCAN_NONE, 1'b0);
                  ncmd_q    <= 2'd2;
                  rd_pend_q <= 1'b1;
                  rd_tot_q  <= (req_chan_i == '0) ? RD_W'(4) : RD_W'(2);
                  keep_q    <= IX_W'(1);
                  base_q    <= req_chan_i;
                  st_q      <= S_CS;
                end
              end
              OP_SCAN_ON: begin
                cmd0_q <= setup_byte(CLKM_PIN);
                cmd1_q <= conv_byte(4'd0, SCAN_UP, 1'b1);
                ncmd_q <= 2'd2;
                scan_q <= 1'b1;
                st_q   <= S_CS;
              end
              OP_SCAN_OFF: begin
                cmd0_q <= setup_byte(CLKM_WRITE);
                ncmd_q <= 2'd1;
                scan_q <= 1'b0;
                st_q   <= S_CS;
              end
              default: err_q <= 1'b1;
            endcase
          end else if (scan_q && eoc_fall) begin
            reading_q <= 1'b1;
            rd_left_q <= RD_W'(2 * NUM_CH);
            keep_q    <= IX_W'(NUM_CH);
            base_q    <= '0;
            widx_q    <= '0;
            par_q     <= 1'b0;
            st_q      <= S_CS;
          end
        end
        S_CS: begin
          cs_q <= 1'b0;
          st_q <= S_GO;
        end
        S_GO: st_q <= S_WAIT;
        S_WAIT: begin
          if (spi_done_i) begin
            if (reading_q) begin
              if (!par_q) hi_q <= spi_rx_i;
              else        widx_q <= widx_q + IX_W'(1);
              par_q     <= ~par_q;
              rd_left_q <= rd_left_q - RD_W'(1);
              if (rd_left_q == RD_W'(1)) begin
                cs_q      <= 1'b1;
                reading_q <= 1'b0;
                st_q      <= S_IDLE;
              end else begin
                st_q <= S_GO;
              end
            end else begin
              cs_q   <= 1'b1;
              cmd0_q <= cmd1_q;
              ncmd_q <= ncmd_q - 2'd1;
              st_q   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (ncmd_q != 2'd0) st_q <= S_CS;
          else if (rd_pend_q) begin
            cnt_q <= '0;
            st_q  <= S_SETTLE;
          end else st_q <= S_IDLE;
        end
        S_SETTLE: begin
          cnt_q <= cnt_q + SW'(1);
          if (cnt_q == SW'(SETTLE_CYC - 1)) begin
            rd_pend_q <= 1'b0;
            reading_q <= 1'b1;
            rd_left_q <= rd_tot_q;
            widx_q    <= '0;
            par_q     <= 1'b0;
            st_q      <= S_CS;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign scan_o       = scan_q;
  assign err_o        = err_q;
  assign cs_no        = cs_q;
  assign spi_start_o  = (st_q == S_GO);
  assign spi_tx_o     = reading_q ? 8'h00 : cmd0_q;
  assign word_valid_o = (st_q == S_WAIT) && spi_done_i && reading_q && par_q && (widx_q < keep_q);
  assign word_o       = {hi_q, spi_rx_i};
  assign word_idx_o   = base_q + CH_W'(widx_q);

  // R2
  start_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start_o |-> !cs_q);

  // R2
  shift_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_busy_i |-> !cs_q);

  // R8
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> cs_q);

  // R9
  reject_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !word_valid_o);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_VIN   = 8,
  parameter int CLK_HZ    = 250_000_000,
  parameter int SCLK_HALF = 4,
  localparam int NUM_CH   = NUM_VIN + 1,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_start_i,
  input  logic [1:0]      req_op_i,
  input  logic [CH_W-1:0] req_chan_i,
  input  logic            eoc_ni,
  output logic            busy_o,
  output logic            scan_active_o,
  output logic            err_o,
  output logic            res_valid_o,
  output logic [CH_W-1:0] res_idx_o,
  output logic [15:0]     res_data_o,
  output logic            spi_sclk_o,
  output logic            spi_mosi_o,
  input  logic            spi_miso_i,
  output logic            spi_cs_no
);
  localparam int SETTLE_CYC = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;

  logic            spi_start, spi_busy, spi_done;
  logic [7:0]      spi_tx, spi_rx;
  logic            word_valid;
  logic [15:0]     word;
  logic [CH_W-1:0] word_idx;

  adc_seq_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_start_i, .req_op_i, .req_chan_i, .eoc_ni,
    .busy_o, .scan_o(scan_active_o), .err_o, .cs_no(spi_cs_no),
    .spi_start_o(spi_start), .spi_tx_o(spi_tx), .spi_busy_i(spi_busy),
    .spi_done_i(spi_done), .spi_rx_i(spi_rx),
    .word_valid_o(word_valid), .word_o(word), .word_idx_o(word_idx)
  );

  adc_spi_byte #(.HALF_DIV(SCLK_HALF)) u_spi (
    .clk_i, .rst_ni, .start_i(spi_start), .tx_i(spi_tx), .miso_i(spi_miso_i),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .busy_o(spi_busy),
    .done_o(spi_done), .rx_o(spi_rx)
  );

  adc_word_fmt #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fmt (
    .clk_i, .rst_ni, .in_valid_i(word_valid), .in_word_i(word), .in_idx_i(word_idx),
    .res_valid_o, .res_idx_o, .res_data_o
  );

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int NV     = 8;
  localparam int NCH    = NV + 1;
  localparam int CW     = 4;
  localparam int CLKHZ  = 100_000;
  localparam int SETTLE = CLKHZ / 1000;

  // single-read vectors: [15:12] channel index, [11:0] response seed
  localparam logic [15:0] VEC [6] = '{16'h13A5, 16'h3C0F, 16'h8FFF, 16'h0123, 16'h5800, 16'h2ABC};

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [CW-1:0] chan = '0;
  logic          eoc_n = 1'b1;
  logic          busy, scan_act, err, rvalid, sclk, mosi, miso, cs_n;
  logic [CW-1:0] ridx;
  logic [15:0]   rdata;

  always #2 clk = ~clk;  // 250 MHz

  adc_seq_top #(.NUM_VIN(NV), .CLK_HZ(CLKHZ), .SCLK_HALF(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_op_i(op), .req_chan_i(chan),
    .eoc_ni(eoc_n), .busy_o(busy), .scan_active_o(scan_act), .err_o(err),
    .res_valid_o(rvalid), .res_idx_o(ridx), .res_data_o(rdata),
    .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_no(cs_n)
  );

  int tests = 0, fails = 0, cyc = 0, err_cnt = 0;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (err) err_cnt++;

  // ADC model
  logic [11:0] rsp_seed = 12'h000;
  int fb = 0, nb = 0, frm_cnt = 0;
  bit in_frame = 0;
  logic [7:0] sh = '0, b0 = '0;
  int frm_n [64], frm_b0 [64], frm_st [64], frm_en [64];

  function automatic logic [15:0] rsp_word(int w);
    return {4'hF, rsp_seed + 12'(w * 12'h135)};
  endfunction

  logic [15:0] cur_w;
  assign cur_w = rsp_word(fb / 16);
  assign miso  = cs_n ? 1'b0 : cur_w[15 - (fb % 16)];

  always @(negedge cs_n) begin fb = 0; nb = 0; in_frame = 1; frm_st[frm_cnt] = cyc; end
  always @(posedge sclk) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    if (fb % 8 == 7) begin
      if (nb == 0) b0 = sh;
      nb++;
    end
  end
  always @(negedge sclk) if (!cs_n) fb++;
  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    frm_n[frm_cnt] = nb; frm_b0[frm_cnt] = int'(b0); frm_en[frm_cnt] = cyc;
    frm_cnt++;
  end

  int r_cnt = 0;
  int r_idx [32], r_dat [32];
  always @(negedge clk) if (rvalid) begin
    r_idx[r_cnt] = int'(ridx); r_dat[r_cnt] = int'(rdata); r_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(logic [1:0] o, logic [CW-1:0] c);
    @(negedge clk); op = o; chan = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int fmt(int idx, logic [15:0] w);
    return (idx == 0) ? int'(w[11:0]) : int'(w[11:2]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int fm, rm, ch, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs idle in reset", int'(cs_n), 1);
    chk("R1 no result in reset", int'(rvalid), 0);
    chk("R1 no scan in reset", int'(scan_act), 0);
    chk("R1 no err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy during boot", int'(busy), 1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R1 boot frame count", frm_cnt, 1);
    chk("R1 boot byte", frm_b0[0], 8'h20);
    chk("R1 boot frame length", frm_n[0], 1);

    // R3 R4 R10 single reads from the vector table
    foreach (VEC[i]) begin
      logic [15:0] w;
      ch = int'(VEC[i][15:12]);
      rsp_seed = VEC[i][11:0];
      fm = frm_cnt; rm = r_cnt;
      request(2'd0, CW'(ch));
      w = rsp_word(0);
      chk("R3 frames per read", frm_cnt - fm, 3);
      chk("R2 setup frame one byte", frm_n[fm], 1);
      chk("R3 setup byte", frm_b0[fm], 8'h68);
      chk("R2 conv frame one byte", frm_n[fm+1], 1);
      if (ch == 0) begin
        chk("R4 temp conv byte", frm_b0[fm+1], 8'h87);
        chk("R4 temp read length", frm_n[fm+2], 4);
      end else begin
        chk("R3 volt conv byte", frm_b0[fm+1], 8'h86 | ((ch - 1) << 3));
        chk("R3 volt read length", frm_n[fm+2], 2);
      end
      chk("R2 read mosi zero", frm_b0[fm+2], 0);
      chk("R10 settle gap", int'(frm_st[fm+2] - frm_en[fm+1] >= SETTLE), 1);
      chk("R3 result count", r_cnt - rm, 1);
      chk("R3 result index", r_idx[rm], ch);
      chk(ch == 0 ? "R4 temp data" : "R3 volt data", r_dat[rm], fmt(ch, w));
    end

    // R9 out-of-range index and reserved op
    fm = frm_cnt; e0 = err_cnt;
    request(2'd0, CW'(NCH));
    request(2'd0, CW'(15));
    request(2'd3, CW'(1));
    repeat (10) @(negedge clk);
    chk("R9 err pulses", err_cnt - e0, 3);
    chk("R9 no traffic", frm_cnt - fm, 0);

    // R6 eoc ignored outside scan
    fm = frm_cnt;
    @(negedge clk); eoc_n = 1'b0;
    repeat (4) @(negedge clk); eoc_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R6 eoc ignored when idle", frm_cnt - fm, 0);

    // R5 scan on
    fm = frm_cnt;
    request(2'd1, '0);
    chk("R5 frames", frm_cnt - fm, 2);
    chk("R5 setup byte", frm_b0[fm], 8'h48);
    chk("R5 conv byte", frm_b0[fm+1], 8'h83);
    chk("R5 scan active", int'(scan_act), 1);

    // R8 single read rejected during scan
    fm = frm_cnt; e0 = err_cnt;
    request(2'd0, CW'(2));
    repeat (10) @(negedge clk);
    chk("R8 err pulse", err_cnt - e0, 1);
    chk("R8 no traffic", frm_cnt - fm, 0);

    // R6 scan burst
    rsp_seed = 12'h7E1;
    fm = frm_cnt; rm = r_cnt;
    @(negedge clk); eoc_n = 1'b0;
    repeat (4) @(negedge clk); eoc_n = 1'b1;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 burst frames", frm_cnt - fm, 1);
    chk("R6 burst length", frm_n[fm], 2 * NCH);
    chk("R6 result count", r_cnt - rm, NCH);
    for (int k = 0; k < NCH; k++) begin
      chk("R6 burst index", r_idx[rm+k], k);
      chk("R6 burst data", r_dat[rm+k], fmt(k, rsp_word(k)));
    end

    // R7 scan off
    fm = frm_cnt;
    request(2'd2, '0);
    chk("R7 frames", frm_cnt - fm, 1);
    chk("R7 setup byte", frm_b0[fm], 8'h68);
    chk("R7 scan cleared", int'(scan_act), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule